// File: doc/BRIEF.md
# Register-Amount Barrel Shifter with Carry

This block shifts or rotates a 32-bit word by an amount taken from an 8-bit field, the low byte of a general register. It supports logical left, logical right, arithmetic right and rotate right. Alongside the shifted word it produces the carry-out that a flag-setting data-processing step needs. The carry follows exact rules for a zero amount, for an amount of exactly the word width, and for any larger amount.

Operands arrive on a valid/ready stream and leave on a registered valid/ready stream one cycle later. The input is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result and carry hold steady and no new operand is taken. Each accepted operand gives exactly one result, in order.

Top module: `reg_shifter`

## Requirements
- R1: The shift type is selected by `in_kind`: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right. An accepted operand shows its result with `out_valid` high on the next clock edge.
- R2: For every shift type, an amount of 0 returns the operand unchanged and copies `in_carry` to `out_carry`.
- R3: A logical left shift by 1 to 31 returns the operand shifted left, with zeros filled in. The carry is operand bit (32 - amount).
- R4: A logical left shift by exactly 32 returns 0 with carry equal to operand bit 0. Any larger amount returns 0 with carry 0.
- R5: A logical right shift by 1 to 31 returns the operand shifted right, with zeros filled in. The carry is operand bit (amount - 1).
- R6: A logical right shift by exactly 32 returns 0 with carry equal to operand bit 31. Any larger amount returns 0 with carry 0.
- R7: An arithmetic right shift by 1 to 31 fills with bit 31, and the carry is bit (amount - 1). Any amount of 32 or more sets every result bit and the carry to operand bit 31.
- R8: A rotate right uses only the amount modulo 32. When that remainder is nonzero, it returns the operand rotated right by it, with carry equal to bit (remainder - 1).
- R9: A rotate by a nonzero amount whose low 5 bits are zero returns the operand unchanged, with carry equal to bit 31.
- R10: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_data`, `out_carry` and `out_valid` hold their values.
- R11: While `rst_n` is low, `out_valid` is 0. A result the sink has taken with no new operand behind it clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand beat present |
| in_ready | output | 1 | Block can take an operand this cycle |
| in_data | input | 32 | Word to shift |
| in_amt | input | 8 | Shift amount (register low byte) |
| in_kind | input | 2 | Shift type, encoded as in R1 |
| in_carry | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Sink takes the result this cycle |
| out_data | output | 32 | Shifted or rotated word |
| out_carry | output | 1 | Shifter carry-out |

## Verification
Each shift type is driven with operands whose end bits differ, such as 0x80000001 and 0x12345678. This makes a carry taken from the wrong bit position visible. Amounts of 0, small values, exactly 32, just above 32 and large values such as 200 separate the in-range path from the two saturated regimes. Rotate amounts of 36 and 64 show whether the modulo-32 reduction and the multiple-of-32 carry rule are applied. A stalled sink with a second operand waiting shows whether results hold and keep their order.

// File: rtl/shft_pkg.sv
package shft_pkg;
  typedef enum logic [1:0] {
    SK_LSL = 2'd0,
    SK_LSR = 2'd1,
    SK_ASR = 2'd2,
    SK_ROR = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/shft_lin_unit.sv
// Non-rotating shift path. One extra bit beside the word catches the last
// bit shifted out, so the carry falls out of the same shifter.
module shft_lin_unit #(
  parameter int W  = 32,
  parameter int AW = 8,
  parameter shft_pkg::shift_kind_e KIND = shft_pkg::SK_LSL
) (
  input  logic [W-1:0]  op,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  res,
  output logic          cout
);
  import shft_pkg::*;

  generate
    if (KIND == SK_LSL) begin : g_lsl
      logic [W:0] wide;
      assign wide = {1'b0, op} << amt;
      assign res  = wide[W-1:0];
      assign cout = wide[W];
    end else if (KIND == SK_LSR) begin : g_lsr
      logic [W:0] wide;
      assign wide = {op, 1'b0} >> amt;
      assign res  = wide[W:1];
      assign cout = wide[0];
    end else begin : g_asr
      logic signed [W:0] wide;
      assign wide = $signed({op, 1'b0}) >>> amt;
      assign res  = wide[W:1];
      assign cout = wide[0];
    end
  endgenerate
endmodule

// File: rtl/shft_rot_unit.sv
// Rotate path. Only the low log2(W) bits of the amount reach it. The carry
// is the new top bit, which also covers a zero remainder (bit W-1).
module shft_rot_unit #(
  parameter int W = 32,
  localparam int LW = $clog2(W)
) (
  input  logic [W-1:0]  op,
  input  logic [LW-1:0] amt_lo,
  output logic [W-1:0]  res,
  output logic          cout
);
  logic [2*W-1:0] dbl;

  assign dbl  = {op, op} >> amt_lo;
  assign res  = dbl[W-1:0];
  assign cout = dbl[W-1];
endmodule

// File: rtl/shft_outreg.sv
// Output stage: one register slot with valid/ready handshake.
module shft_outreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  input  logic         up_carry,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data,
  output logic         dn_carry
);
  logic take;

  assign up_ready = !dn_valid || dn_ready;
  assign take     = up_valid && up_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
      dn_carry <= 1'b0;
    end else if (take) begin
      dn_valid <= 1'b1;
      dn_data  <= up_data;
      dn_carry <= up_carry;
    end else if (dn_ready) begin
      dn_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/reg_shifter.sv
module reg_shifter #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [AMT_W-1:0]  in_amt,
  input  logic [1:0]        in_kind,
  input  logic              in_carry,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_carry
);
  import shft_pkg::*;

  localparam int LW     = $clog2(DATA_W);
  localparam int N_LIN  = 3;

  logic [DATA_W-1:0] lin_res  [N_LIN];
  logic              lin_cout [N_LIN];
  logic [DATA_W-1:0] rot_res;
  logic              rot_cout;
  logic [DATA_W-1:0] nxt_data;
  logic              nxt_carry;
  shift_kind_e       kind;

  assign kind = shift_kind_e'(in_kind);

  generate
    for (genvar k = 0; k < N_LIN; k++) begin : g_lin
      shft_lin_unit #(
        .W    (DATA_W),
        .AW   (AMT_W),
        .KIND (shift_kind_e'(k))
      ) u_lin (
        .op   (in_data),
        .amt  (in_amt),
        .res  (lin_res[k]),
        .cout (lin_cout[k])
      );
    end
  endgenerate

  shft_rot_unit #(.W(DATA_W)) u_rot (
    .op     (in_data),
    .amt_lo (in_amt[LW-1:0]),
    .res    (rot_res),
    .cout   (rot_cout)
  );

  always_comb begin
    if (in_amt == '0) begin
      nxt_data  = in_data;
      nxt_carry = in_carry;
    end else begin
      case (kind)
        SK_LSL:  begin nxt_data = lin_res[0]; nxt_carry = lin_cout[0]; end
        SK_LSR:  begin nxt_data = lin_res[1]; nxt_carry = lin_cout[1]; end
        SK_ASR:  begin nxt_data = lin_res[2]; nxt_carry = lin_cout[2]; end
        default: begin nxt_data = rot_res;    nxt_carry = rot_cout;    end
      endcase
    end
  end

  shft_outreg #(.W(DATA_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (nxt_data),
    .up_carry (nxt_carry),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (out_data),
    .dn_carry (out_carry)
  );
endmodule

// File: rtl/reg_shifter_chk.sv
module reg_shifter_chk #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic [AMT_W-1:0]  in_amt,
  input logic [1:0]        in_kind,
  input logic              in_carry,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_carry
);
  localparam int LW = $clog2(DATA_W);
  logic acc;
  assign acc = in_valid && in_ready;

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) acc |=> out_valid); // R1
  AST_ZERO_AMT_PASS: assert property (@(posedge clk) disable iff (!rst_n) (acc && in_amt == '0) |=> (out_data == $past(in_data) && out_carry == $past(in_carry))); // R2
  AST_LSL_BEYOND: assert property (@(posedge clk) disable iff (!rst_n) (acc && in_kind == 2'd0 && in_amt > AMT_W'(DATA_W)) |=> (out_data == '0 && !out_carry)); // R4
  AST_LSR_BEYOND: assert property (@(posedge clk) disable iff (!rst_n) (acc && in_kind == 2'd1 && in_amt > AMT_W'(DATA_W)) |=> (out_data == '0 && !out_carry)); // R6
  AST_ASR_FILL: assert property (@(posedge clk) disable iff (!rst_n) (acc && in_kind == 2'd2 && in_amt >= AMT_W'(DATA_W)) |=> (out_data == {DATA_W{$past(in_data[DATA_W-1])}} && out_carry == $past(in_data[DATA_W-1]))); // R7
  AST_ROR_WHOLE_TURN: assert property (@(posedge clk) disable iff (!rst_n) (acc && in_kind == 2'd3 && in_amt != '0 && in_amt[LW-1:0] == '0) |=> (out_data == $past(in_data) && out_carry == $past(in_data[DATA_W-1]))); // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_carry))); // R10
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |-> !in_ready); // R10
  AST_DRAIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_ready && !in_valid) |=> !out_valid); // R11
endmodule

bind reg_shifter reg_shifter_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (.*);

// File: tb/reg_shifter_tb.sv
module reg_shifter_tb;
  localparam int NV = 17;
  // {kind[2], amt[8], cin, data[32], exp_data[32], exp_carry}
  localparam logic [75:0] VECS [NV] = '{
    {2'd0, 8'd0,   1'b1, 32'h8000_0001, 32'h8000_0001, 1'b1},  // R2
    {2'd0, 8'd1,   1'b0, 32'h8000_0001, 32'h0000_0002, 1'b1},  // R3
    {2'd0, 8'd4,   1'b0, 32'h1234_5678, 32'h2345_6780, 1'b1},  // R3
    {2'd0, 8'd32,  1'b0, 32'h8000_0001, 32'h0000_0000, 1'b1},  // R4
    {2'd0, 8'd33,  1'b1, 32'h8000_0001, 32'h0000_0000, 1'b0},  // R4
    {2'd1, 8'd1,   1'b0, 32'h8000_0001, 32'h4000_0000, 1'b1},  // R5
    {2'd1, 8'd4,   1'b0, 32'h1234_5678, 32'h0123_4567, 1'b1},  // R5
    {2'd1, 8'd32,  1'b0, 32'h8000_0001, 32'h0000_0000, 1'b1},  // R6
    {2'd1, 8'd200, 1'b1, 32'h8000_0001, 32'h0000_0000, 1'b0},  // R6
    {2'd2, 8'd4,   1'b1, 32'h8765_4321, 32'hF876_5432, 1'b0},  // R7
    {2'd2, 8'd40,  1'b0, 32'h8000_0000, 32'hFFFF_FFFF, 1'b1},  // R7
    {2'd2, 8'd32,  1'b1, 32'h7FFF_FFFF, 32'h0000_0000, 1'b0},  // R7
    {2'd3, 8'd8,   1'b1, 32'h1234_5678, 32'h7812_3456, 1'b0},  // R8
    {2'd3, 8'd36,  1'b0, 32'h1234_5678, 32'h8123_4567, 1'b1},  // R8
    {2'd3, 8'd64,  1'b0, 32'h8000_0001, 32'h8000_0001, 1'b1},  // R9
    {2'd3, 8'd0,   1'b0, 32'h8000_0001, 32'h8000_0001, 1'b0},  // R2
    {2'd2, 8'd0,   1'b1, 32'h0000_0005, 32'h0000_0005, 1'b1}   // R2
  };
  localparam string VTAG [NV] = '{"R2","R3","R3","R4","R4","R5","R5","R6","R6",
                                  "R7","R7","R7","R8","R8","R9","R2","R2"};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic [7:0]  in_amt = '0;
  logic [1:0]  in_kind = '0;
  logic        in_carry = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        out_carry;
  int          n_chk = 0;
  int          n_fail = 0;

  always #4 clk = ~clk;

  reg_shifter u_dut (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset out_valid", 64'(out_valid), 64'd0);
    check("R10 reset in_ready", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table, one beat each, sink always ready
    for (int i = 0; i < NV; i++) begin
      {in_kind, in_amt, in_carry, in_data} = VECS[i][75:33];
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check({VTAG[i], " R1 valid"}, 64'(out_valid), 64'd1);
      check({VTAG[i], " data"}, 64'(out_data), 64'(VECS[i][32:1]));
      check({VTAG[i], " carry"}, 64'(out_carry), 64'(VECS[i][0]));
    end
    @(negedge clk);
    check("R11 drained", 64'(out_valid), 64'd0);

    // Back-pressure: stall sink with a second beat waiting
    out_ready = 1'b0;
    in_kind = 2'd0; in_amt = 8'd1; in_data = 32'h0000_0001; in_carry = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    check("R10 first held data", 64'(out_data), 64'h2);
    check("R10 in_ready low", 64'(in_ready), 64'd0);
    in_kind = 2'd1; in_amt = 8'd1; in_data = 32'h0000_0010; in_carry = 1'b0;
    @(negedge clk);
    check("R10 still valid", 64'(out_valid), 64'd1);
    check("R10 data stable", 64'(out_data), 64'h2);
    check("R10 carry stable", 64'(out_carry), 64'd0);
    out_ready = 1'b1;
    #1;
    check("R10 in_ready high", 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 second beat data", 64'(out_data), 64'h8);
    check("R10 second beat valid", 64'(out_valid), 64'd1);
    @(negedge clk);
    check("R11 empty after drain", 64'(out_valid), 64'd0);

    // Reset with a beat held
    out_ready = 1'b0;
    in_kind = 2'd3; in_amt = 8'd4; in_data = 32'h0000_00F1; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 held rotate", 64'(out_data), 64'h1000_000F);
    rst_n = 1'b0;
    @(negedge clk);
    check("R11 reset clears", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule